// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupt Detection

This block is a bank of general-purpose I/O lines behind a 32-bit register port. Software sets the value each line drives, chooses per line whether the line is an input or an output, can invert the sense of each input, and can flag lines for blinking. The blink flags and the blink counter selection are passed out to a separate waveform generator. The bank reports the inverted-as-configured input value. The same adjusted value drives interrupt detection.

Each input line has two interrupt sources. The level source is the adjusted input itself. The edge source is a sticky cause bit that is set whenever the adjusted input goes from 0 to 1. Software clears cause bits by writing 0 to them. Each source has its own enable mask. A line is pending when either of its enabled sources is active. Pending lines are ORed in groups of eight, and each group drives one summary interrupt output.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the edge cause, edge mask and level mask registers all read 0, every summary interrupt is 0, and every line is an input (pin_oe all 0).
- R2: Byte offsets are: 0x00 output value, 0x04 direction, 0x08 blink enable, 0x0C input polarity, 0x10 input value, 0x14 edge cause, 0x18 edge mask, 0x1C level mask, 0x20 blink counter select. A direction bit of 1 makes the line an input. A direction bit of 0 drives pin_out for that line from the matching output-value bit, with pin_oe set to 1.
- R3: The input value at 0x10 is the pin level after a two-flop synchroniser, XORed with the polarity bit. A pin change is visible to the interrupt logic two clock edges after it is applied.
- R4: An edge cause bit is set when its adjusted input goes from 0 to 1. With polarity 0 this is a rising pin edge. With polarity 1 it is a falling pin edge. The opposite pin edge sets nothing.
- R5: A write to 0x14 clears each cause bit written as 0 and leaves each bit written as 1 unchanged.
- R6: If a new edge and a clearing write reach the same cause bit in the same cycle, the bit ends up set.
- R7: A line with its level mask bit set is pending for as long as its adjusted input is 1, and stops being pending when the input returns to 0.
- R8: A line with its edge mask bit set is pending while its cause bit is 1, even after the input has gone back to 0. A cause bit whose mask bit is 0 raises no interrupt.
- R9: Summary output k is the OR of the pending bits of lines 8k to 8k+7.
- R10: Read data appears on the cycle after the read is accepted. Unmapped offsets read as 0.
- R11: The blink enable and blink counter select registers read back what was written and drive blink_en and blink_sel.
- R12: Writes to the input value register at 0x10 have no effect on what it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | N_LINES | Raw pin levels |
| pin_out | output | N_LINES | Output value per line |
| pin_oe | output | N_LINES | Output enable per line (1 = driven) |
| blink_en | output | N_LINES | Blink request per line |
| blink_sel | output | N_LINES | Blink counter choice per line |
| irq_group | output | N_LINES/8 rounded up | Summary interrupt per group of eight lines |

## Verification
Each result has a fixed latency, counted in clock edges from the falling clock edge where the bench applies a stimulus:

- Register writes take effect at the next edge.
- Read data is due after one edge.
- The adjusted input, and so any level interrupt, changes after exactly two edges.
- An edge cause bit, and any edge interrupt, sets after three edges.

The bench drives and samples only on falling edges and counts these edges explicitly. It checks that a level interrupt is still 0 after one edge and 1 after two. It applies the clearing write in the exact cycle in which a new edge lands, to test the same-cycle case. Line-by-line sweeps over all 32 lines cover rising and falling detection, masking and group mapping.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_OUT    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_BLINK  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_POL    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_DIN    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CAUSE  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_EMASK  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_LMASK  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_BSEL   = 8'h20;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= raw_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_in,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] clr_keep,
  output logic [WIDTH-1:0] cause
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] cause_q;
  logic [WIDTH-1:0] cause_d;
  logic [WIDTH-1:0] rise;

  always_comb begin
    rise    = level_in & ~prev_q;
    cause_d = cause_q;
    if (clr_en) begin
      cause_d = cause_q & clr_keep;
    end
    cause_d = cause_d | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= level_in;
      cause_q <= cause_d;
    end
  end

  assign cause = cause_q;
endmodule

// File: rtl/gpio_irq_fold.sv
module gpio_irq_fold #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned GROUP = 8,
  localparam int unsigned NGRP = (WIDTH + GROUP - 1) / GROUP
) (
  input  logic [WIDTH-1:0] pending,
  output logic [NGRP-1:0]  summary
);
  logic [NGRP*GROUP-1:0] padded;

  always_comb begin
    padded = '0;
    padded[WIDTH-1:0] = pending;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign summary[g] = |padded[g*GROUP +: GROUP];
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned GROUP   = 8,
  localparam int unsigned NGRP   = (N_LINES + GROUP - 1) / GROUP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_valid,
  input  logic               reg_write,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [N_LINES-1:0] pin_in,
  output logic [N_LINES-1:0] pin_out,
  output logic [N_LINES-1:0] pin_oe,
  output logic [N_LINES-1:0] blink_en,
  output logic [N_LINES-1:0] blink_sel,
  output logic [NGRP-1:0]    irq_group
);
  logic [N_LINES-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q, bsel_q;
  logic [N_LINES-1:0] out_d, dir_d, blink_d, pol_d, emask_d, lmask_d, bsel_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic [N_LINES-1:0] sync_lvl, adj_in, cause, pending, wbits;
  logic               wr_en, rd_en, cause_clr;

  function automatic logic [DATA_W-1:0] widen(input logic [N_LINES-1:0] v);
    logic [DATA_W-1:0] t;
    t = '0;
    t[N_LINES-1:0] = v;
    return t;
  endfunction

  assign wr_en     = reg_valid & reg_write;
  assign rd_en     = reg_valid & ~reg_write;
  assign wbits     = reg_wdata[N_LINES-1:0];
  assign cause_clr = wr_en & (reg_addr == OFS_CAUSE);

  gpio_in_sync #(.WIDTH(N_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .sync_out(sync_lvl)
  );

  assign adj_in = sync_lvl ^ pol_q;

  gpio_edge_cause #(.WIDTH(N_LINES)) u_cause (
    .clk(clk), .rst_n(rst_n), .level_in(adj_in),
    .clr_en(cause_clr), .clr_keep(wbits), .cause(cause)
  );

  assign pending = (adj_in & lmask_q) | (cause & emask_q);

  gpio_irq_fold #(.WIDTH(N_LINES), .GROUP(GROUP)) u_fold (
    .pending(pending), .summary(irq_group)
  );

  always_comb begin
    out_d   = out_q;
    dir_d   = dir_q;
    blink_d = blink_q;
    pol_d   = pol_q;
    emask_d = emask_q;
    lmask_d = lmask_q;
    bsel_d  = bsel_q;
    if (wr_en) begin
      case (reg_addr)
        OFS_OUT:   out_d   = wbits;
        OFS_DIR:   dir_d   = wbits;
        OFS_BLINK: blink_d = wbits;
        OFS_POL:   pol_d   = wbits;
        OFS_EMASK: emask_d = wbits;
        OFS_LMASK: lmask_d = wbits;
        OFS_BSEL:  bsel_d  = wbits;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      case (reg_addr)
        OFS_OUT:   rdata_d = widen(out_q);
        OFS_DIR:   rdata_d = widen(dir_q);
        OFS_BLINK: rdata_d = widen(blink_q);
        OFS_POL:   rdata_d = widen(pol_q);
        OFS_DIN:   rdata_d = widen(adj_in);
        OFS_CAUSE: rdata_d = widen(cause);
        OFS_EMASK: rdata_d = widen(emask_q);
        OFS_LMASK: rdata_d = widen(lmask_q);
        OFS_BSEL:  rdata_d = widen(bsel_q);
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
      bsel_q  <= '0;
      rdata_q <= '0;
    end else begin
      out_q   <= out_d;
      dir_q   <= dir_d;
      blink_q <= blink_d;
      pol_q   <= pol_d;
      emask_q <= emask_d;
      lmask_q <= lmask_d;
      bsel_q  <= bsel_d;
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign pin_out   = out_q;
  assign pin_oe    = ~dir_q;
  assign blink_en  = blink_q;
  assign blink_sel = bsel_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned NGRP    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_valid,
  input logic               reg_write,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [N_LINES-1:0] pin_oe,
  input logic [N_LINES-1:0] adj_in,
  input logic [N_LINES-1:0] cause,
  input logic [N_LINES-1:0] emask_q,
  input logic [N_LINES-1:0] lmask_q,
  input logic [NGRP-1:0]    irq_group
);
  logic [N_LINES-1:0] adj_seen_q;
  logic [N_LINES-1:0] new_rise;
  logic               clr_wr, unmapped_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adj_seen_q <= '0;
    else        adj_seen_q <= adj_in;
  end

  assign new_rise    = adj_in & ~adj_seen_q;
  assign clr_wr      = reg_valid & reg_write & (reg_addr == OFS_CAUSE);
  assign unmapped_rd = reg_valid & ~reg_write & (reg_addr > OFS_BSEL || reg_addr[1:0] != 2'b00);

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((cause & $past(cause)) == $past(cause))); // R5
  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (new_rise != '0) |=> ((cause & $past(new_rise)) == $past(new_rise))); // R6
  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && reg_addr == OFS_DIR) |=> (pin_oe == ~$past(reg_wdata[N_LINES-1:0]))); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_rd |=> (reg_rdata == '0)); // R10
  AST_LEVEL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ((adj_in & lmask_q) != '0) |-> (irq_group != '0)); // R7
  AST_NO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (emask_q == '0 && lmask_q == '0) |-> (irq_group == '0)); // R9
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N_LINES(N_LINES), .NGRP(NGRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .pin_oe(pin_oe), .adj_in(adj_in), .cause(cause), .emask_q(emask_q),
  .lmask_q(lmask_q), .irq_group(irq_group)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  logic        clk, rst_n;
  logic        reg_valid, reg_write;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [31:0] pin_in, pin_out, pin_oe, blink_en, blink_sel;
  logic [3:0]  irq_group;
  int          checks, fails;
  logic [31:0] rd;

  gpio_irq_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .blink_en(blink_en),
    .blink_sel(blink_sel), .irq_group(irq_group)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    d = reg_rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0;
    reg_wdata = '0; pin_in = '0;
    waitn(3);
    rst_n = 1'b1;
    waitn(1);

    // R1 reset state
    rdreg(8'h14, rd); check("R1 cause", rd, 32'h0);
    rdreg(8'h18, rd); check("R1 emask", rd, 32'h0);
    rdreg(8'h1C, rd); check("R1 lmask", rd, 32'h0);
    check("R1 irq", {28'h0, irq_group}, 32'h0);
    check("R1 oe", pin_oe, 32'h0);

    // R2 output value and direction
    wr(8'h00, 32'hA5C3_0F96);
    wr(8'h04, 32'h0000_FFFF);
    check("R2 pin_out", pin_out, 32'hA5C3_0F96);
    check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    rdreg(8'h00, rd); check("R2 out readback", rd, 32'hA5C3_0F96);
    wr(8'h04, 32'hFFFF_FFFF);
    check("R2 all inputs", pin_oe, 32'h0);

    // R11 blink registers
    wr(8'h08, 32'h1234_5678); wr(8'h20, 32'h8765_4321);
    check("R11 blink_en", blink_en, 32'h1234_5678);
    check("R11 blink_sel", blink_sel, 32'h8765_4321);
    rdreg(8'h08, rd); check("R11 blink rb", rd, 32'h1234_5678);
    rdreg(8'h20, rd); check("R11 bsel rb", rd, 32'h8765_4321);

    // R3 and R12: input value under several pin/polarity patterns
    for (int p = 0; p < 4; p++) begin
      logic [31:0] pv, pp;
      pv = 32'h0F0F_3C3C << p;
      pp = 32'hFF00_AA55 ^ (32'h1 << (p * 7));
      wr(8'h0C, pp);
      pin_in = pv;
      waitn(3);
      rdreg(8'h10, rd); check("R3 data in", rd, pv ^ pp);
      wr(8'h10, ~rd);
      rdreg(8'h10, rd); check("R12 write ignored", rd, pv ^ pp);
    end
    pin_in = '0; wr(8'h0C, 32'h0); waitn(3);
    wr(8'h14, 32'h0);
    rdreg(8'h14, rd); check("R5 cleared", rd, 32'h0);

    // R4 rising edges with polarity 0, every line
    for (int i = 0; i < 32; i++) begin
      pin_in = 32'h1 << i; waitn(3);
      rdreg(8'h14, rd); check("R4 rise latched", rd, 32'h1 << i);
      wr(8'h14, 32'h0);
      pin_in = '0; waitn(3);
      rdreg(8'h14, rd); check("R4 fall ignored pol0", rd, 32'h0);
    end

    // R4 falling edges with polarity 1, every line
    wr(8'h0C, 32'hFFFF_FFFF); waitn(3); wr(8'h14, 32'h0);
    pin_in = 32'hFFFF_FFFF; waitn(3);
    rdreg(8'h14, rd); check("R4 rise ignored pol1", rd, 32'h0);
    for (int i = 0; i < 32; i++) begin
      pin_in = ~(32'h1 << i); waitn(3);
      rdreg(8'h14, rd); check("R4 fall latched", rd, 32'h1 << i);
      wr(8'h14, 32'h0);
      pin_in = 32'hFFFF_FFFF; waitn(3);
    end
    pin_in = '0; wr(8'h0C, 32'h0); waitn(3); wr(8'h14, 32'h0);

    // R5 selective clear
    pin_in = 32'hF; waitn(3); pin_in = '0; waitn(3);
    wr(8'h14, 32'hFFFF_FFFA);
    rdreg(8'h14, rd); check("R5 keep ones", rd, 32'hA);
    wr(8'h14, 32'h0);

    // R6 edge and clear in the same cycle
    for (int i = 0; i < 32; i += 9) begin
      pin_in = 32'h1 << i;
      waitn(2);
      wr(8'h14, 32'h0);
      rdreg(8'h14, rd); check("R6 edge wins", rd, 32'h1 << i);
      pin_in = '0; waitn(3); wr(8'h14, 32'h0);
    end

    // R7 and R9 level sweep over every line, with latency
    wr(8'h1C, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      pin_in = 32'h1 << i;
      waitn(1); check("R3 latency one edge", {28'h0, irq_group}, 32'h0);
      waitn(1); check("R9 group map", {28'h0, irq_group}, 32'h1 << (i / 8));
      pin_in = '0; waitn(2);
      check("R7 level drops", {28'h0, irq_group}, 32'h0);
    end
    pin_in = 32'h0100_0100; waitn(2);
    check("R9 two groups", {28'h0, irq_group}, 32'hA);
    wr(8'h1C, 32'h0);
    check("R8 masked level", {28'h0, irq_group}, 32'h0);
    pin_in = '0; waitn(3);
    rdreg(8'h14, rd); check("R8 cause set unmasked", rd !== 32'h0, 32'h1);
    check("R8 cause no irq", {28'h0, irq_group}, 32'h0);
    wr(8'h14, 32'h0);

    // R8 edge interrupt persists after pin drops
    wr(8'h18, 32'h0001_0000);
    pin_in = 32'h0001_0000; waitn(3); pin_in = '0; waitn(3);
    check("R8 edge irq held", {28'h0, irq_group}, 32'h4);
    wr(8'h14, 32'h0);
    check("R8 edge irq cleared", {28'h0, irq_group}, 32'h0);
    wr(8'h18, 32'h0);

    // R10 unmapped reads
    rdreg(8'h24, rd); check("R10 unmapped 0x24", rd, 32'h0);
    rdreg(8'h80, rd); check("R10 unmapped 0x80", rd, 32'h0);
    rdreg(8'h04, rd); check("R10 next-cycle read", rd, 32'hFFFF_FFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule